// File: doc/BRIEF.md
# Low-Power Mode Controller

This block moves a device between normal operation and three sleep levels of increasing depth: light sleep, deep sleep and full shutdown. Each level gates a different set of clock domains: the CPU clock, one enable per peripheral, the oscillator and the PLL. Each level also accepts its own class of wake event.

Software selects a level on `mode_req` and pulses `enter`. The controller then drops the matching enables on the next clock edge. In light sleep, only the peripherals flagged in `keep_mask` keep their clocks, and an interrupt from one of those peripherals wakes the device. Deep sleep keeps only the oscillator and PLL running and waits for an external interrupt. Full shutdown stops everything and responds only to the non-maskable interrupt or to reset. On that wake path the controller restarts the oscillator and PLL, then holds the CPU and peripheral clocks off for a programmable settling count before it returns to normal operation.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the controller is in run: `cpu_clk_en`=1, every `periph_clk_en` bit =1, `osc_en`=1, `pll_en`=1, `mode`=2'b00.
- R2: In run, `enter`=1 with `mode_req` nonzero moves the controller on the next edge to the requested level (2'b01 light sleep, 2'b10 deep sleep, 2'b11 shutdown), and `mode` shows that code. `mode_req`=2'b00 keeps it in run.
- R3: In light sleep, `cpu_clk_en`=0, `periph_clk_en` equals `keep_mask` as sampled on the entry edge, and `osc_en`=`pll_en`=1.
- R4: Light sleep returns to run on the edge after any `periph_irq` bit whose captured mask bit is 1. Interrupts from peripherals whose mask bit is 0, `ext_irq` and `nmi` have no effect there.
- R5: In deep sleep, `cpu_clk_en`=0, all `periph_clk_en` bits are 0, and `osc_en`=`pll_en`=1.
- R6: Deep sleep returns to run on the edge after `ext_irq`=1. `periph_irq` and `nmi` have no effect there.
- R7: In shutdown, all enables are 0.
- R8: Only `nmi` (or reset) leaves shutdown. `periph_irq` and `ext_irq` have no effect there.
- R9: After `nmi` in shutdown, `osc_en`=`pll_en`=1 while `cpu_clk_en` and `periph_clk_en` stay 0 and `mode` stays 2'b11. This lasts for `stab_count`+1 cycles, with `stab_count` sampled with `nmi`. Run follows.
- R10: `enter` is ignored in every state other than run.
- R11: Asserting `rst_n` low forces the run outputs at once, without waiting for a clock edge, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Requested level: 01 light, 10 deep, 11 shutdown |
| enter | input | 1 | Strobe that applies `mode_req` |
| keep_mask | input | NPERIPH | Peripherals kept clocked in light sleep |
| periph_irq | input | NPERIPH | Enabled interrupt per peripheral |
| ext_irq | input | 1 | External interrupt event |
| nmi | input | 1 | Non-maskable external interrupt |
| stab_count | input | STAB_W | Oscillator settling cycles minus one |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | NPERIPH | Per-peripheral clock gate enables |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| mode | output | 2 | Current level, 11 also during settling |

## Verification
A corrupted state register appears on the very next cycle as a wrong combination of the enables and `mode`, because every output decodes directly from the state. A bad captured mask shows up as a wrong `periph_clk_en` pattern on the first light-sleep cycle. A bad settling counter shows up as run being reached a cycle early or late after `nmi`. The bench compares every output every cycle against a model, so such errors are caught within one cycle of appearing.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int NPERIPH = 8,
  parameter int STAB_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_req,
  input  logic               enter,
  input  logic [NPERIPH-1:0] keep_mask,
  input  logic [NPERIPH-1:0] periph_irq,
  input  logic               ext_irq,
  input  logic               nmi,
  input  logic [STAB_W-1:0]  stab_count,
  output logic               cpu_clk_en,
  output logic [NPERIPH-1:0] periph_clk_en,
  output logic               osc_en,
  output logic               pll_en,
  output logic [1:0]         mode
);
  localparam logic [2:0] S_RUN = 3'd0, S_LIGHT = 3'd1, S_DEEP = 3'd2,
                         S_OFF = 3'd3, S_SETTLE = 3'd4;

  logic [2:0]         st;
  logic [NPERIPH-1:0] mask_q;
  logic [STAB_W-1:0]  cnt;

  wire light_wake = |(periph_irq & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RUN;
      mask_q <= '0;
      cnt    <= '0;
    end else begin
      case (st)
        S_RUN:    if (enter && mode_req != 2'b00) begin
                    st     <= {1'b0, mode_req};
                    mask_q <= keep_mask;
                  end
        S_LIGHT:  if (light_wake) st <= S_RUN;
        S_DEEP:   if (ext_irq) st <= S_RUN;
        S_OFF:    if (nmi) begin
                    st  <= S_SETTLE;
                    cnt <= stab_count;
                  end
        S_SETTLE: if (cnt == '0) st <= S_RUN;
                  else cnt <= cnt - 1'b1;
        default:  st <= S_RUN;
      endcase
    end
  end

  assign cpu_clk_en    = (st == S_RUN);
  assign periph_clk_en = (st == S_RUN) ? '1 : (st == S_LIGHT) ? mask_q : '0;
  assign osc_en        = (st != S_OFF);
  assign pll_en        = (st != S_OFF);
  assign mode          = (st == S_SETTLE) ? 2'b11 : st[1:0];

  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && enter && mode_req != 2'b00) |=> (mode == $past(mode_req)));
  p_light_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LIGHT && light_wake) |=> (cpu_clk_en && mode == 2'b00));
  p_deep_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEEP && ext_irq) |=> (cpu_clk_en && osc_en));
  p_off_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFF && !nmi) |=> (st == S_OFF && !osc_en));
  p_settle_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE && cnt != '0) |=> (st == S_SETTLE && cnt == $past(cnt) - 1'b1));
  p_ignore_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEEP && !ext_irq) |=> (st == S_DEEP));
endmodule

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int SW = 16;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode_req = 0;
  logic enter = 0, ext_irq = 0, nmi = 0;
  logic [NP-1:0] keep_mask = 0, periph_irq = 0;
  logic [SW-1:0] stab_count = 0;
  logic cpu_clk_en, osc_en, pll_en;
  logic [NP-1:0] periph_clk_en;
  logic [1:0] mode;

  int n_chk = 0, n_bad = 0;
  int m_st = 0;
  logic [NP-1:0] m_mask = 0;
  logic [SW-1:0] m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_ctrl #(.NPERIPH(NP), .STAB_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .enter(enter),
    .keep_mask(keep_mask), .periph_irq(periph_irq), .ext_irq(ext_irq),
    .nmi(nmi), .stab_count(stab_count), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en), .pll_en(pll_en), .mode(mode));

  function automatic logic [NP+4:0] expect_out(int s, logic [NP-1:0] mk);
    case (s)
      0: return {1'b1, {NP{1'b1}}, 1'b1, 1'b1, 2'b00};
      1: return {1'b0, mk,         1'b1, 1'b1, 2'b01};
      2: return {1'b0, {NP{1'b0}}, 1'b1, 1'b1, 2'b10};
      3: return {1'b0, {NP{1'b0}}, 1'b0, 1'b0, 2'b11};
      default: return {1'b0, {NP{1'b0}}, 1'b1, 1'b1, 2'b11};
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R2"; 1: return "R3"; 2: return "R5"; 3: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag);
    logic [NP+4:0] act, exp;
    act = {cpu_clk_en, periph_clk_en, osc_en, pll_en, mode};
    exp = expect_out(m_st, m_mask);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    case (m_st)
      0: if (enter && mode_req != 2'b00) begin m_st = int'(mode_req); m_mask = keep_mask; end
      1: if (|(periph_irq & m_mask)) m_st = 0;
      2: if (ext_irq) m_st = 0;
      3: if (nmi) begin m_st = 4; m_cnt = stab_count; end
      default: if (m_cnt == 0) m_st = 0; else m_cnt = m_cnt - 1'b1;
    endcase
  endtask

  task automatic step(string tag);
    @(posedge clk); #1;
    if (rst_n) model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic quiet();
    enter = 0; periph_irq = 0; ext_irq = 0; nmi = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); check("R1");
    @(negedge clk); rst_n = 1; check("R1");
    step("R1");

    // light sleep with mask 0x05; masked-off irq, ext_irq, nmi, enter ignored
    mode_req = 2'b01; keep_mask = 8'h05; enter = 1; step("R2");
    quiet(); keep_mask = 8'hFF; check("R3");
    periph_irq = 8'h02; ext_irq = 1; nmi = 1; step("R4");
    quiet(); enter = 1; mode_req = 2'b11; step("R10");
    quiet(); periph_irq = 8'h04; step("R4");
    quiet();
    // deep sleep: periph irq and nmi ignored, ext wakes
    mode_req = 2'b10; enter = 1; step("R5");
    quiet(); periph_irq = 8'hFF; nmi = 1; step("R6");
    quiet(); ext_irq = 1; step("R6");
    quiet();
    // shutdown: ext/periph ignored, nmi with settle 3
    mode_req = 2'b11; enter = 1; step("R7");
    quiet(); ext_irq = 1; periph_irq = 8'hFF; step("R8");
    quiet(); nmi = 1; stab_count = 16'd3; step("R9");
    quiet(); stab_count = 16'd9;
    for (int i = 0; i < 5; i++) step("R9");
    // settle 0
    mode_req = 2'b11; enter = 1; step("R7");
    quiet(); nmi = 1; stab_count = 0; step("R9");
    quiet(); step("R9"); step("R9");
    // async reset from shutdown
    mode_req = 2'b11; enter = 1; step("R7");
    quiet(); #2; rst_n = 0; #1; m_st = 0; check("R11");
    @(negedge clk); rst_n = 1; check("R1");

    for (int i = 0; i < 4000; i++) begin
      mode_req   = 2'($urandom % 4);
      enter      = ($urandom % 4) == 0;
      keep_mask  = NP'($urandom);
      periph_irq = (($urandom % 6) == 0) ? NP'(1 << ($urandom % NP)) : '0;
      ext_irq    = ($urandom % 8) == 0;
      nmi        = ($urandom % 10) == 0;
      stab_count = SW'($urandom % 8);
      step(tag_of(m_st));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule